// File: doc/BRIEF.md
# Packet statistics counter bank

This block watches a transmit and a receive streaming interface and keeps six 64-bit event counters. On each side it counts start-of-packet beats, end-of-packet beats and errored beats. Only a beat where valid and ready are both high is counted. The end-of-packet counters serve as the packet counts, since each packet ends exactly once. The block also records two error pulses from an external loopback FIFO: a write into a full FIFO and a read from an empty one. Both are held as sticky flags in a status word.

Software reads the counters through a small read port. The port is combinational on a byte address and returns 32 bits. Each counter takes two consecutive word addresses, low word first, then high word. Reads always return a set of shadow registers and never the live counters. A snapshot command copies all six live counters at once, so the two words of one counter are always consistent with each other. A second command zeroes the shadow set. A third command zeroes the live counters and the status flags. That third command is a self-clearing bit in the control word.

Top module: `pkt_stat_bank`

## Requirements
- R1: A counter increments by exactly one on a clock edge where its interface has valid and ready both high and the matching flag (SOP, EOP or error) is high. Any other edge leaves it unchanged. The SOP, EOP and error of one beat may count together.
- R2: Read offsets are as follows. Offset 0x00 is the control word and offset 0x0C is the status word. The counters are at 0x20/0x24 TX SOP, 0x28/0x2C TX EOP, 0x30/0x34 TX error, 0x38/0x3C RX SOP, 0x40/0x44 RX EOP and 0x48/0x4C RX error, with the low word at the lower address. Every other address reads zero.
- R3: Counter reads return the shadow copies. A change in a live counter is not visible at the read port until a snapshot is taken.
- R4: A control write with bit 6 set copies all six live counters into the shadow set. The copied values are those held just before that write's clock edge.
- R5: A control write with bit 7 set zeroes all shadow registers at that edge. If bit 6 is also set in the same write, the zeroing wins.
- R6: A control write with bit 8 set shows bit 8 in the control word for one cycle. At the next edge the live counters and the status flags become zero, and bit 8 reads back as zero afterwards.
- R7: When a live-counter clear and a counted beat fall on the same edge, the counter ends at zero.
- R8: Status bit 0 is the FIFO write-while-full flag and status bit 1 is the FIFO read-while-empty flag. Each bit is set by its input pulse and stays set until a live-counter clear.
- R9: After reset, every readable word is zero.
- R10: Control bits other than bit 8 read back at offset 0x00 exactly as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txValid | input | 1 | Transmit beat valid |
| txReady | input | 1 | Transmit beat accepted |
| txSop | input | 1 | Transmit start-of-packet flag |
| txEop | input | 1 | Transmit end-of-packet flag |
| txErr | input | 1 | Transmit error flag |
| rxValid | input | 1 | Receive beat valid |
| rxReady | input | 1 | Receive beat accepted |
| rxSop | input | 1 | Receive start-of-packet flag |
| rxEop | input | 1 | Receive end-of-packet flag |
| rxErr | input | 1 | Receive error flag |
| fifoOvf | input | 1 | Loopback FIFO write-while-full pulse |
| fifoUnf | input | 1 | Loopback FIFO read-while-empty pulse |
| ctrlWe | input | 1 | Control word write strobe |
| ctrlWdata | input | 32 | Control word write data |
| rdAddr | input | 8 | Read byte address |
| rdData | output | 32 | Read data for rdAddr |

## Verification
Two pairs of events can land on the same edge. The first pair is a live-counter clear and a counted beat. The bench provokes it by driving an end-of-packet beat in the cycle after a bit-8 write, then taking a snapshot, and expects zero. The second pair is a snapshot and a shadow clear issued in one write, where the read-back must be zero. The same collisions also come up many times in a long random phase, where a behavioural model predicts every readable word on every cycle.

// File: rtl/pkt_stat_pkg.sv
package pkt_stat_pkg;

  localparam int unsigned NUM_EVENTS = 6;
  localparam int unsigned CTRL_SNAP_BIT = 6;
  localparam int unsigned CTRL_SHADOW_CLR_BIT = 7;
  localparam int unsigned CTRL_LIVE_CLR_BIT = 8;

  localparam int unsigned OFS_CTRL = 'h00;
  localparam int unsigned OFS_STATUS = 'h0C;
  localparam int unsigned OFS_CNT_BASE = 'h20;

  typedef enum logic [2:0] {
    EV_TX_SOP = 3'd0,
    EV_TX_EOP = 3'd1,
    EV_TX_ERR = 3'd2,
    EV_RX_SOP = 3'd3,
    EV_RX_EOP = 3'd4,
    EV_RX_ERR = 3'd5
  } event_idx_e;

  typedef struct packed {
    logic snap;
    logic shadowClr;
    logic liveClr;
  } stat_strobe_t;

endpackage

// File: rtl/pkt_stat_ctrl.sv
module pkt_stat_ctrl
  import pkt_stat_pkg::*;
#(
  parameter int unsigned BUS_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWe,
  input  logic [BUS_W-1:0] ctrlWdata,
  output logic [BUS_W-1:0] ctrlReg,
  output stat_strobe_t     strobes
);

  // Control word; the live-clear bit drops by itself one cycle after it is set
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (ctrlWe) begin
      ctrlReg <= ctrlWdata;
    end else begin
      ctrlReg[CTRL_LIVE_CLR_BIT] <= 1'b0;
    end
  end

  always_comb begin
    strobes.snap      = ctrlWe & ctrlWdata[CTRL_SNAP_BIT];
    strobes.shadowClr = ctrlWe & ctrlWdata[CTRL_SHADOW_CLR_BIT];
    strobes.liveClr   = ctrlReg[CTRL_LIVE_CLR_BIT];
  end

endmodule

// File: rtl/pkt_stat_dp.sv
module pkt_stat_dp
  import pkt_stat_pkg::*;
#(
  parameter int unsigned NUM_EV = NUM_EVENTS,
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_EV-1:0]            evHit,
  input  logic                         fifoOvf,
  input  logic                         fifoUnf,
  input  stat_strobe_t                 strobes,
  input  logic [BUS_W-1:0]             ctrlReg,
  input  logic [ADDR_W-1:0]            rdAddr,
  output logic [BUS_W-1:0]             rdData,
  output logic [NUM_EV-1:0][CNT_W-1:0] liveVal,
  output logic [NUM_EV-1:0][CNT_W-1:0] shadowVal,
  output logic [1:0]                   statusBits
);

  localparam int unsigned WORDS_PER_CNT = CNT_W / BUS_W;
  localparam int unsigned BYTES_PER_WORD = BUS_W / 8;

  logic [1:0] errPulse;
  assign errPulse = {fifoUnf, fifoOvf};

  for (genvar e = 0; e < NUM_EV; e++) begin : g_cnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        liveVal[e] <= '0;
      end else if (strobes.liveClr) begin
        liveVal[e] <= '0;
      end else if (evHit[e]) begin
        liveVal[e] <= liveVal[e] + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shadowVal[e] <= '0;
      end else if (strobes.shadowClr) begin
        shadowVal[e] <= '0;
      end else if (strobes.snap) begin
        shadowVal[e] <= liveVal[e];
      end
    end
  end

  for (genvar s = 0; s < 2; s++) begin : g_sticky
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        statusBits[s] <= 1'b0;
      end else if (strobes.liveClr) begin
        statusBits[s] <= 1'b0;
      end else if (errPulse[s]) begin
        statusBits[s] <= 1'b1;
      end
    end
  end

  logic [ADDR_W-1:0] cntOfs;
  assign cntOfs = rdAddr - ADDR_W'(OFS_CNT_BASE);

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_W'(OFS_CTRL)) begin
      rdData = ctrlReg;
    end else if (rdAddr == ADDR_W'(OFS_STATUS)) begin
      rdData = BUS_W'(statusBits);
    end else if (rdAddr >= ADDR_W'(OFS_CNT_BASE)) begin
      for (int e = 0; e < NUM_EV; e++) begin
        for (int w = 0; w < WORDS_PER_CNT; w++) begin
          if (cntOfs == ADDR_W'((e * WORDS_PER_CNT + w) * BYTES_PER_WORD)) begin
            rdData = shadowVal[e][w*BUS_W +: BUS_W];
          end
        end
      end
    end
  end

endmodule

// File: rtl/pkt_stat_bank.sv
module pkt_stat_bank
  import pkt_stat_pkg::*;
#(
  parameter int unsigned NUM_EV = NUM_EVENTS,
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txValid,
  input  logic              txReady,
  input  logic              txSop,
  input  logic              txEop,
  input  logic              txErr,
  input  logic              rxValid,
  input  logic              rxReady,
  input  logic              rxSop,
  input  logic              rxEop,
  input  logic              rxErr,
  input  logic              fifoOvf,
  input  logic              fifoUnf,
  input  logic              ctrlWe,
  input  logic [BUS_W-1:0]  ctrlWdata,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BUS_W-1:0]  rdData
);

  logic                         txHit;
  logic                         rxHit;
  logic [NUM_EV-1:0]            evHit;
  logic [BUS_W-1:0]             ctrlReg;
  stat_strobe_t                 strobes;
  logic [NUM_EV-1:0][CNT_W-1:0] liveVal;
  logic [NUM_EV-1:0][CNT_W-1:0] shadowVal;
  logic [1:0]                   statusBits;

  assign txHit = txValid & txReady;
  assign rxHit = rxValid & rxReady;

  always_comb begin
    evHit            = '0;
    evHit[EV_TX_SOP] = txHit & txSop;
    evHit[EV_TX_EOP] = txHit & txEop;
    evHit[EV_TX_ERR] = txHit & txErr;
    evHit[EV_RX_SOP] = rxHit & rxSop;
    evHit[EV_RX_EOP] = rxHit & rxEop;
    evHit[EV_RX_ERR] = rxHit & rxErr;
  end

  pkt_stat_ctrl #(.BUS_W(BUS_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlWe   (ctrlWe),
    .ctrlWdata(ctrlWdata),
    .ctrlReg  (ctrlReg),
    .strobes  (strobes)
  );

  pkt_stat_dp #(
    .NUM_EV(NUM_EV),
    .CNT_W (CNT_W),
    .BUS_W (BUS_W),
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .evHit     (evHit),
    .fifoOvf   (fifoOvf),
    .fifoUnf   (fifoUnf),
    .strobes   (strobes),
    .ctrlReg   (ctrlReg),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .liveVal   (liveVal),
    .shadowVal (shadowVal),
    .statusBits(statusBits)
  );

endmodule

// File: rtl/pkt_stat_chk.sv
module pkt_stat_chk
  import pkt_stat_pkg::*;
#(
  parameter int unsigned NUM_EV = NUM_EVENTS,
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned BUS_W  = 32
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         txValid,
  input logic                         txReady,
  input logic                         txEop,
  input logic                         ctrlWe,
  input logic [BUS_W-1:0]             ctrlWdata,
  input stat_strobe_t                 strobes,
  input logic [NUM_EV-1:0][CNT_W-1:0] liveVal,
  input logic [NUM_EV-1:0][CNT_W-1:0] shadowVal,
  input logic [1:0]                   statusBits
);

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.liveClr && txValid && txReady && txEop
      |=> liveVal[EV_TX_EOP] == $past(liveVal[EV_TX_EOP]) + 1'b1);

  assert_count_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.liveClr && !(txValid && txReady) |=> $stable(liveVal[EV_TX_EOP]));

  assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrlWe && (ctrlWdata[CTRL_SNAP_BIT] || ctrlWdata[CTRL_SHADOW_CLR_BIT]))
      |=> $stable(shadowVal));

  assert_shadow_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWe && ctrlWdata[CTRL_SHADOW_CLR_BIT] |=> shadowVal == '0);

  assert_selfclear_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWe && ctrlWdata[CTRL_LIVE_CLR_BIT] |=> strobes.liveClr);

  assert_selfclear_once_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.liveClr && !ctrlWe |=> !strobes.liveClr);

  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.liveClr |=> liveVal == '0 && statusBits == 2'b00);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    statusBits != 2'b00 && !strobes.liveClr |=> (statusBits & $past(statusBits)) == $past(statusBits));

endmodule

bind pkt_stat_bank pkt_stat_chk #(
  .NUM_EV(NUM_EV),
  .CNT_W (CNT_W),
  .BUS_W (BUS_W)
) u_chk (.*);

// File: tb/sim_pkt_stat_bank.sv
`timescale 1ns/1ps
module sim_pkt_stat_bank;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN;
  logic        txValid, txReady, txSop, txEop, txErr;
  logic        rxValid, rxReady, rxSop, rxEop, rxErr;
  logic        fifoOvf, fifoUnf;
  logic        ctrlWe;
  logic [31:0] ctrlWdata;
  logic [7:0]  rdAddr;
  logic [31:0] rdData;

  pkt_stat_bank u0 (.*);

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  longint unsigned liveM[6];
  longint unsigned shadowM[6];
  bit          ovfM, unfM;
  logic [31:0] ctrlM;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s addr=0x%02h got=0x%08h expected=0x%08h", tag, rdAddr, got, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    int idx;
    if (a == 8'h00) return ctrlM;
    if (a == 8'h0C) return {30'd0, unfM, ovfM};
    if (a >= 8'h20 && a < 8'h50 && a[1:0] == 2'b00) begin
      idx = (int'(a) - 'h20) / 8;
      return a[2] ? shadowM[idx][63:32] : shadowM[idx][31:0];
    end
    return 32'd0;
  endfunction

  function automatic string tagFor(input logic [7:0] a);
    if (a == 8'h00) return "R10";
    if (a == 8'h0C) return "R8";
    if (a >= 8'h20 && a < 8'h50) return "R3";
    return "R2";
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 6; i++) begin
      liveM[i] = 0;
      shadowM[i] = 0;
    end
    ovfM = 0;
    unfM = 0;
    ctrlM = '0;
  endtask

  // One clock: advance the reference model at the edge, compare at the falling edge
  task automatic step();
    bit clrNow;
    bit ev[6];
    @(posedge clk);
    if (rstN) begin
      clrNow = ctrlM[8];
      ev[0] = txValid & txReady & txSop;
      ev[1] = txValid & txReady & txEop;
      ev[2] = txValid & txReady & txErr;
      ev[3] = rxValid & rxReady & rxSop;
      ev[4] = rxValid & rxReady & rxEop;
      ev[5] = rxValid & rxReady & rxErr;
      if (ctrlWe && ctrlWdata[7]) begin
        for (int i = 0; i < 6; i++) shadowM[i] = 0;
      end else if (ctrlWe && ctrlWdata[6]) begin
        for (int i = 0; i < 6; i++) shadowM[i] = liveM[i];
      end
      for (int i = 0; i < 6; i++) liveM[i] = clrNow ? 0 : liveM[i] + (ev[i] ? 1 : 0);
      ovfM = clrNow ? 1'b0 : (ovfM | fifoOvf);
      unfM = clrNow ? 1'b0 : (unfM | fifoUnf);
      if (ctrlWe) ctrlM = ctrlWdata;
      else ctrlM[8] = 1'b0;
    end
    @(negedge clk);
    chk(tagFor(rdAddr), rdData, modelRead(rdAddr));
  endtask

  task automatic idleInputs();
    {txValid, txReady, txSop, txEop, txErr} = '0;
    {rxValid, rxReady, rxSop, rxEop, rxErr} = '0;
    fifoOvf = 0;
    fifoUnf = 0;
    ctrlWe = 0;
    ctrlWdata = '0;
  endtask

  task automatic readAt(input logic [7:0] a, input string tag, input logic [31:0] exp);
    rdAddr = a;
    #1;
    chk(tag, rdData, exp);
  endtask

  task automatic ctrlWrite(input logic [31:0] d);
    ctrlWe = 1;
    ctrlWdata = d;
    step();
    ctrlWe = 0;
    ctrlWdata = '0;
  endtask

  initial begin
    rstN = 0;
    rdAddr = '0;
    idleInputs();
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    step();

    // R9: every word zero after reset
    for (int a = 0; a < 'h54; a += 4) readAt(8'(a), "R9", 32'd0);

    // R1: five accepted EOP beats, three stalled beats
    txValid = 1; txReady = 1; txEop = 1;
    repeat (5) step();
    txReady = 0;
    repeat (3) step();
    idleInputs();
    readAt(8'h28, "R3", 32'd0);
    ctrlWrite(32'h40);
    readAt(8'h28, "R1_R4", 32'd5);
    readAt(8'h2C, "R2", 32'd0);
    readAt(8'h20, "R1", 32'd0);
    readAt(8'h00, "R10", 32'h40);

    // R5: snapshot and shadow clear together, clear wins
    ctrlWrite(32'hC0);
    readAt(8'h28, "R5", 32'd0);

    // R8: sticky overflow flag
    fifoOvf = 1;
    step();
    fifoOvf = 0;
    repeat (3) step();
    readAt(8'h0C, "R8", 32'd1);

    // R6: self-clearing live clear
    ctrlWrite(32'h100);
    readAt(8'h00, "R6", 32'h100);
    // R7: counted beat on the very edge of the clear
    txValid = 1; txReady = 1; txEop = 1;
    step();
    idleInputs();
    readAt(8'h00, "R6", 32'h0);
    readAt(8'h0C, "R6_R8", 32'd0);
    ctrlWrite(32'h40);
    readAt(8'h28, "R7", 32'd0);

    // Random phase compared against the model every cycle
    for (int n = 0; n < 4000; n++) begin
      txValid = 1'($urandom); txReady = 1'($urandom);
      txSop = 1'($urandom); txEop = 1'($urandom); txErr = ($urandom % 5) == 0;
      rxValid = 1'($urandom); rxReady = 1'($urandom);
      rxSop = 1'($urandom); rxEop = 1'($urandom); rxErr = ($urandom % 5) == 0;
      fifoOvf = ($urandom % 40) == 0;
      fifoUnf = ($urandom % 40) == 0;
      ctrlWe = ($urandom % 12) == 0;
      ctrlWdata = $urandom & 32'h0000_01FF;
      if (($urandom % 3) != 0) ctrlWdata[8] = 1'b0;
      rdAddr = (($urandom % 9) == 0) ? 8'($urandom) : 8'(($urandom % 21) * 4);
      step();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired before completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule